// File: doc/BRIEF.md
# Write-Path Error Injector

This block sits on the write path of a single memory channel. It lets a test harness corrupt a chosen write on purpose. Each write request arrives with its decoded DRAM coordinates (DIMM, rank, bank, page, column, and which 32-byte half of the cacheline it carries) together with the ECC check bits the encoder produced. When the injector is armed and the request matches the programmed address pattern, the block can do either or both of two things. It can flip check bits under a 32-bit mask. It can raise a flag that corrupts the address parity. Requests that are not writes, and writes that do not match, pass through unchanged in the same cycle.

Software programs the block through a small register write port. The port holds two halves of a match word, an ECC flip mask, and a control word. The match word and the mask are held in staging registers. They are copied into the active set only when the control word is written. A change made while the injector is armed therefore has no effect until the next control write.

The behaviour is a three-state machine:
- **IDLE**: not armed.
- **ARMED**: the next matching write will be corrupted.
- **SPENT**: a one-shot injection has already fired.

The transitions are:
- **arm**: a control write with the ECC or parity bit set. This is taken from any state.
- **disarm**: a control write with neither inject bit set. This is taken from any state.
- **fire-once**: a matching write while the repeat bit is clear. This moves ARMED to SPENT.
- **fire-repeat**: a matching write while the repeat bit is set. This keeps the state at ARMED.

A control write takes priority over a write that matches in the same cycle.

Top module: `wr_err_inject`

## Requirements
- R1: After reset the unit is not armed. `out_chk` equals `req_chk` and `par_corrupt` is 0 for any request until an arming control write has taken effect.
- R2: The control word is register select 3. Its bits are: bit 0 repeat, bits 2:1 half select, bit 3 ECC inject, bit 4 parity inject. A control write with bit 3 or bit 4 set makes `armed` 1 from the next cycle. A control write with both clear, including one with only the repeat bit, makes `armed` 0 from the next cycle.
- R3: A request with `req_write`=0 never changes `out_chk` and never raises `par_corrupt`.
- R4: The match word is made of two 32-bit halves: select 0 holds the low half and select 1 the high half. Column is compared against bits 13:0, page against bits 29:14, and bank against bits 33:30. A mismatch in any field that is not wildcarded prevents injection.
- R5: Bit 42 of the match word selects the three-DIMM population. When it is 1, the DIMM is compared against bits 36:35 and the rank against bit 34 (with `req_rank[0]`). When it is 0, the DIMM is compared against bit 36 (with `req_dimm[0]`) and the rank against bits 35:34.
- R6: Match-word bits 37, 38, 39, 40 and 41 are don't-care flags. They apply to column, page, bank, rank and DIMM respectively. A set flag removes that field from the comparison.
- R7: Half select 01 allows injection only when `req_upper_half`=0. Half select 10 allows it only when `req_upper_half`=1. Half select 00 or 11 allows either half.
- R8: With repeat clear, the first matching write is corrupted. `armed` is 0 from the next cycle, and later matching writes pass unchanged.
- R9: With repeat set, every matching write is corrupted and `armed` stays 1 until a disarming control write.
- R10: On a hit with ECC inject set, `out_chk` = `req_chk` XOR the active mask. On a hit with parity inject set, `par_corrupt` is 1. The two are independent.
- R11: Writes to the match or mask registers (selects 0–2) do not change the active parameters. Only a control write copies the staged values into the active set.
- R12: Corruption appears combinationally in the same cycle as the matching request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 match low, 1 match high, 2 ECC mask, 3 control |
| reg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write request, 0 = read |
| req_dimm | input | 2 | DIMM number of the request |
| req_rank | input | 2 | Rank number of the request |
| req_bank | input | 4 | Bank number of the request |
| req_page | input | 16 | Page (row) of the request |
| req_col | input | 14 | Column of the request |
| req_upper_half | input | 1 | 1 = upper 32-byte half of the cacheline |
| req_chk | input | 32 | Check bits from the ECC encoder |
| out_chk | output | 32 | Check bits sent on, possibly corrupted |
| par_corrupt | output | 1 | Corrupt address parity for this request |
| armed | output | 1 | Injector is armed |

## Verification
The bench builds the block with its default parameters: 14 column bits, 16 page bits, 4 bank bits and a 32-bit register word. With these values the field boundaries land at bits 14, 30 and 34, the DIMM/rank split at bits 36:34, the wildcard flags at bits 41:37 and the population bit at 42. A single column-, page- or bank-only mismatch can therefore be aimed at each boundary. The same request can also be shown to match under one population setting and miss under the other. The 32-bit mask lets single-symbol and two-symbol flip patterns be checked bit for bit.

// File: rtl/wei_pkg.sv
package wei_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SPENT = 2'd2
    } inj_state_e;

    typedef enum logic [1:0] {
        SEL_MATCH_LO = 2'd0,
        SEL_MATCH_HI = 2'd1,
        SEL_ECC_MASK = 2'd2,
        SEL_CONTROL  = 2'd3
    } reg_sel_e;

    localparam int CTL_W       = 5;
    localparam int CTL_REPEAT  = 0;
    localparam int CTL_HALF_LO = 1;
    localparam int CTL_HALF_HI = 2;
    localparam int CTL_ECC     = 3;
    localparam int CTL_PAR     = 4;

    localparam int WILD_COL  = 0;
    localparam int WILD_PAGE = 1;
    localparam int WILD_BANK = 2;
    localparam int WILD_RANK = 3;
    localparam int WILD_DIMM = 4;
    localparam int WILD_N    = 5;

endpackage

// File: rtl/wei_param_regs.sv
module wei_param_regs
    import wei_pkg::*;
#(
    parameter int REG_W      = 32,
    parameter int MATCH_USED = 43
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [1:0]            reg_sel,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic                  ctl_wr,
    output logic [MATCH_USED-1:0] act_match,
    output logic [REG_W-1:0]      act_mask,
    output logic [CTL_W-1:0]      act_ctl
);
    localparam int HI_W = MATCH_USED - REG_W;

    logic [REG_W-1:0] stage_lo;
    logic [HI_W-1:0]  stage_hi;
    logic [REG_W-1:0] stage_mask;

    assign ctl_wr = reg_we && (reg_sel == SEL_CONTROL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_lo   <= '0;
            stage_hi   <= '0;
            stage_mask <= '0;
        end else if (reg_we) begin
            if (reg_sel == SEL_MATCH_LO) stage_lo   <= reg_wdata;
            if (reg_sel == SEL_MATCH_HI) stage_hi   <= reg_wdata[HI_W-1:0];
            if (reg_sel == SEL_ECC_MASK) stage_mask <= reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_match <= '0;
            act_mask  <= '0;
            act_ctl   <= '0;
        end else if (ctl_wr) begin
            act_match <= {stage_hi, stage_lo};
            act_mask  <= stage_mask;
            act_ctl   <= reg_wdata[CTL_W-1:0];
        end
    end

    // R11: active parameters move only on a control write
    assert_latch_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> ($stable(act_match) && $stable(act_mask) && $stable(act_ctl)));

endmodule

// File: rtl/wei_addr_cmp.sv
module wei_addr_cmp
    import wei_pkg::*;
#(
    parameter int COL_W      = 14,
    parameter int PAGE_W     = 16,
    parameter int BANK_W     = 4,
    parameter int MATCH_USED = 43
) (
    input  logic [MATCH_USED-1:0] match_vec,
    input  logic [1:0]            half_sel,
    input  logic [1:0]            req_dimm,
    input  logic [1:0]            req_rank,
    input  logic [BANK_W-1:0]     req_bank,
    input  logic [PAGE_W-1:0]     req_page,
    input  logic [COL_W-1:0]      req_col,
    input  logic                  req_upper_half,
    output logic                  addr_hit
);
    localparam int PAGE_LSB = COL_W;
    localparam int BANK_LSB = PAGE_LSB + PAGE_W;
    localparam int DR_LSB   = BANK_LSB + BANK_W;
    localparam int WILD_LSB = DR_LSB + 3;
    localparam int POP_BIT  = WILD_LSB + WILD_N;

    logic [WILD_N-1:0] wild;
    logic three_pop;
    logic col_ok, page_ok, bank_ok, dimm_ok, rank_ok, half_ok;

    assign wild      = match_vec[WILD_LSB +: WILD_N];
    assign three_pop = match_vec[POP_BIT];

    assign col_ok  = wild[WILD_COL]  || (match_vec[PAGE_LSB-1:0] == req_col);
    assign page_ok = wild[WILD_PAGE] || (match_vec[BANK_LSB-1:PAGE_LSB] == req_page);
    assign bank_ok = wild[WILD_BANK] || (match_vec[DR_LSB-1:BANK_LSB] == req_bank);

    always_comb begin
        if (three_pop) begin
            dimm_ok = wild[WILD_DIMM] || (match_vec[DR_LSB+2:DR_LSB+1] == req_dimm);
            rank_ok = wild[WILD_RANK] || (match_vec[DR_LSB] == req_rank[0]);
        end else begin
            dimm_ok = wild[WILD_DIMM] || (match_vec[DR_LSB+2] == req_dimm[0]);
            rank_ok = wild[WILD_RANK] || (match_vec[DR_LSB+1:DR_LSB] == req_rank);
        end
    end

    always_comb begin
        unique case (half_sel)
            2'b01:   half_ok = !req_upper_half;
            2'b10:   half_ok = req_upper_half;
            default: half_ok = 1'b1;
        endcase
    end

    assign addr_hit = col_ok && page_ok && bank_ok && dimm_ok && rank_ok && half_ok;

    // R7: a lower-half-only selection never accepts an upper-half request
    always_comb begin
        assert_half_lower_R7: assert (!(half_sel == 2'b01 && req_upper_half && addr_hit));
    end

endmodule

// File: rtl/wei_arm_fsm.sv
module wei_arm_fsm
    import wei_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_data,
    input  logic             act_repeat,
    input  logic             fire,
    output logic             armed
);
    inj_state_e state, state_nx;
    logic arm_req;

    assign arm_req = ctl_data[CTL_ECC] || ctl_data[CTL_PAR];

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ctl_wr && arm_req) state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (ctl_wr)                   state_nx = arm_req ? ST_ARMED : ST_IDLE;
                else if (fire && !act_repeat) state_nx = ST_SPENT;
            end
            ST_SPENT: begin
                if (ctl_wr) state_nx = arm_req ? ST_ARMED : ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        armed = (state == ST_ARMED);
    end

    // R2: arming and disarming take effect one cycle after the control write
    assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && arm_req) |=> armed);
    assert_disarm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !arm_req) |=> !armed);
    // R8: a one-shot injection disarms after firing
    assert_oneshot_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !ctl_wr && !act_repeat) |=> !armed);
    // R9: repeat mode stays armed until a control write
    assert_repeat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && act_repeat && !ctl_wr) |=> armed);

endmodule

// File: rtl/wr_err_inject.sv
module wr_err_inject
    import wei_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int COL_W  = 14,
    parameter int PAGE_W = 16,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_dimm,
    input  logic [1:0]        req_rank,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_upper_half,
    input  logic [REG_W-1:0]  req_chk,
    output logic [REG_W-1:0]  out_chk,
    output logic              par_corrupt,
    output logic              armed
);
    localparam int MATCH_USED = COL_W + PAGE_W + BANK_W + 3 + WILD_N + 1;

    logic                  ctl_wr;
    logic [MATCH_USED-1:0] act_match;
    logic [REG_W-1:0]      act_mask;
    logic [CTL_W-1:0]      act_ctl;
    logic                  addr_hit;
    logic                  fire;

    wei_param_regs #(.REG_W(REG_W), .MATCH_USED(MATCH_USED)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctl_wr(ctl_wr), .act_match(act_match),
        .act_mask(act_mask), .act_ctl(act_ctl)
    );

    wei_addr_cmp #(.COL_W(COL_W), .PAGE_W(PAGE_W), .BANK_W(BANK_W),
                   .MATCH_USED(MATCH_USED)) u_cmp (
        .match_vec(act_match), .half_sel(act_ctl[CTL_HALF_HI:CTL_HALF_LO]),
        .req_dimm(req_dimm), .req_rank(req_rank), .req_bank(req_bank),
        .req_page(req_page), .req_col(req_col),
        .req_upper_half(req_upper_half), .addr_hit(addr_hit)
    );

    wei_arm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr),
        .ctl_data(reg_wdata[CTL_W-1:0]), .act_repeat(act_ctl[CTL_REPEAT]),
        .fire(fire), .armed(armed)
    );

    assign fire = armed && req_valid && req_write && addr_hit;

    always_comb begin
        out_chk     = req_chk;
        par_corrupt = 1'b0;
        if (fire) begin
            if (act_ctl[CTL_ECC]) out_chk = req_chk ^ act_mask;
            par_corrupt = act_ctl[CTL_PAR];
        end
    end

    // R3: reads pass untouched
    assert_read_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |-> (out_chk == req_chk && !par_corrupt));
    // R1: nothing is corrupted while not armed
    assert_idle_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (out_chk == req_chk && !par_corrupt));

endmodule

// File: tb/test_wr_err_inject.sv
module test_wr_err_inject;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_dimm = '0;
    logic [1:0]  req_rank = '0;
    logic [3:0]  req_bank = '0;
    logic [15:0] req_page = '0;
    logic [13:0] req_col = '0;
    logic        req_upper_half = 1'b0;
    logic [31:0] req_chk = 32'h0F0F_0F0F;
    logic [31:0] out_chk;
    logic        par_corrupt;
    logic        armed;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    wr_err_inject i_wr_err_inject (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .req_valid(req_valid), .req_write(req_write),
        .req_dimm(req_dimm), .req_rank(req_rank), .req_bank(req_bank),
        .req_page(req_page), .req_col(req_col), .req_upper_half(req_upper_half),
        .req_chk(req_chk), .out_chk(out_chk), .par_corrupt(par_corrupt),
        .armed(armed)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic [31:0] m_lo;
        logic [31:0] m_hi;
        logic [31:0] mask;
        logic [7:0]  ctrl;
        logic [1:0]  dimm;
        logic [1:0]  rank;
        logic [3:0]  bank;
        logic [15:0] page;
        logic [13:0] col;
        logic        upper;
        logic        wr;
        logic        hit;
    } vec_t;

    localparam int NV = 15;
    // match 0x19_6FBBC123: col 0x123, page 0xBEEF, bank 5, dimm 1, rank 2 (two-DIMM)
    localparam vec_t VECS [NV] = '{
        '{4'd4,  32'h6FBBC123, 32'h019, 32'h00000003, 8'h08, 2'd1, 2'd2, 4'd5, 16'hBEEF, 14'h0123, 1'b0, 1'b1, 1'b1}, // R4 exact
        '{4'd4,  32'h6FBBC123, 32'h019, 32'h00000003, 8'h08, 2'd1, 2'd2, 4'd5, 16'hBEEF, 14'h0124, 1'b0, 1'b1, 1'b0}, // R4 col
        '{4'd4,  32'h6FBBC123, 32'h019, 32'h00000003, 8'h08, 2'd1, 2'd2, 4'd5, 16'hBEEE, 14'h0123, 1'b0, 1'b1, 1'b0}, // R4 page
        '{4'd4,  32'h6FBBC123, 32'h019, 32'h00000003, 8'h08, 2'd1, 2'd2, 4'd4, 16'hBEEF, 14'h0123, 1'b0, 1'b1, 1'b0}, // R4 bank
        '{4'd6,  32'h6FBBC123, 32'h039, 32'h00000003, 8'h10, 2'd1, 2'd2, 4'd5, 16'hBEEF, 14'h3FFF, 1'b0, 1'b1, 1'b1}, // R6 col wild, parity
        '{4'd10, 32'h00000000, 32'h3E0, 32'h00010001, 8'h18, 2'd0, 2'd3, 4'hA, 16'h1234, 14'h0042, 1'b1, 1'b1, 1'b1}, // R10 all wild both
        '{4'd3,  32'h6FBBC123, 32'h019, 32'h00000003, 8'h08, 2'd1, 2'd2, 4'd5, 16'hBEEF, 14'h0123, 1'b0, 1'b0, 1'b0}, // R3 read
        '{4'd5,  32'h6FBBC123, 32'h415, 32'h80000000, 8'h08, 2'd2, 2'd1, 4'd5, 16'hBEEF, 14'h0123, 1'b0, 1'b1, 1'b1}, // R5 three-DIMM
        '{4'd5,  32'h6FBBC123, 32'h015, 32'h80000000, 8'h08, 2'd2, 2'd1, 4'd5, 16'hBEEF, 14'h0123, 1'b0, 1'b1, 1'b0}, // R5 two-DIMM split
        '{4'd7,  32'h6FBBC123, 32'h019, 32'h0000FF00, 8'h0A, 2'd1, 2'd2, 4'd5, 16'hBEEF, 14'h0123, 1'b1, 1'b1, 1'b0}, // R7 lower only, upper req
        '{4'd7,  32'h6FBBC123, 32'h019, 32'h0000FF00, 8'h0A, 2'd1, 2'd2, 4'd5, 16'hBEEF, 14'h0123, 1'b0, 1'b1, 1'b1}, // R7 lower only, lower req
        '{4'd7,  32'h6FBBC123, 32'h019, 32'h0000FF00, 8'h0C, 2'd1, 2'd2, 4'd5, 16'hBEEF, 14'h0123, 1'b1, 1'b1, 1'b1}, // R7 upper only
        '{4'd7,  32'h6FBBC123, 32'h019, 32'h0000FF00, 8'h0E, 2'd1, 2'd2, 4'd5, 16'hBEEF, 14'h0123, 1'b1, 1'b1, 1'b1}, // R7 full line
        '{4'd5,  32'h6FBBC123, 32'h019, 32'h00000003, 8'h08, 2'd1, 2'd1, 4'd5, 16'hBEEF, 14'h0123, 1'b0, 1'b1, 1'b0}, // R5 rank miss
        '{4'd6,  32'h6FBBC123, 32'h219, 32'h00000003, 8'h08, 2'd0, 2'd2, 4'd5, 16'hBEEF, 14'h0123, 1'b0, 1'b1, 1'b1}  // R6 dimm wild
    };

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", rq, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic drive_req(input logic wr, input logic [1:0] d, input logic [1:0] r,
                             input logic [3:0] b, input logic [15:0] p,
                             input logic [13:0] c, input logic up);
        req_valid = 1'b1; req_write = wr; req_dimm = d; req_rank = r;
        req_bank = b; req_page = p; req_col = c; req_upper_half = up;
        #2;
    endtask

    task automatic idle_req();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_errors++;
        $display("FAIL watchdog: actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, request passes
        drive_req(1'b1, 2'd1, 2'd2, 4'd5, 16'hBEEF, 14'h0123, 1'b0);
        check(armed == 1'b0, "R1 armed", {31'd0, armed}, 32'd0);
        check(out_chk == req_chk && !par_corrupt, "R1 passthru", out_chk, req_chk);
        idle_req();

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [31:0] exp_chk;
            logic        exp_par;
            reg_write(2'd0, VECS[i].m_lo);
            reg_write(2'd1, VECS[i].m_hi);
            reg_write(2'd2, VECS[i].mask);
            reg_write(2'd3, {24'd0, VECS[i].ctrl});
            drive_req(VECS[i].wr, VECS[i].dimm, VECS[i].rank, VECS[i].bank,
                      VECS[i].page, VECS[i].col, VECS[i].upper);
            exp_chk = (VECS[i].hit && VECS[i].ctrl[3]) ? (req_chk ^ VECS[i].mask) : req_chk;
            exp_par = VECS[i].hit && VECS[i].ctrl[4];
            check(out_chk == exp_chk, $sformatf("R%0d vec%0d chk", VECS[i].rq, i), out_chk, exp_chk);
            check(par_corrupt == exp_par, $sformatf("R%0d vec%0d par", VECS[i].rq, i),
                  {31'd0, par_corrupt}, {31'd0, exp_par});
            idle_req();
            reg_write(2'd3, 32'd0);
        end

        // R2: repeat-only control does not arm; ECC arms; zero disarms
        reg_write(2'd3, 32'h01);
        #2 check(armed == 1'b0, "R2 repeat-only", {31'd0, armed}, 32'd0);
        reg_write(2'd3, 32'h08);
        #2 check(armed == 1'b1, "R2 arm", {31'd0, armed}, 32'd1);
        reg_write(2'd3, 32'h00);
        #2 check(armed == 1'b0, "R2 disarm", {31'd0, armed}, 32'd0);

        // R8 one-shot, R12 same-cycle corruption
        reg_write(2'd0, 32'h0);
        reg_write(2'd1, 32'h3E0);
        reg_write(2'd2, 32'h000000FF);
        reg_write(2'd3, 32'h08);
        drive_req(1'b1, 2'd0, 2'd0, 4'd0, 16'h0, 14'h0, 1'b0);
        check(out_chk == (32'h0F0F_0F0F ^ 32'hFF), "R12 same cycle", out_chk, 32'h0F0F_0F0F ^ 32'hFF);
        @(negedge clk);
        #2;
        check(armed == 1'b0, "R8 disarmed", {31'd0, armed}, 32'd0);
        check(out_chk == req_chk, "R8 second write clean", out_chk, req_chk);
        idle_req();

        // R9 repeat keeps corrupting
        reg_write(2'd3, 32'h19);
        for (int k = 0; k < 3; k++) begin
            if (k == 0) drive_req(1'b1, 2'd0, 2'd0, 4'd0, 16'h0, 14'h0, 1'b0);
            else begin @(negedge clk); #2; end
            check(out_chk == (req_chk ^ 32'hFF) && par_corrupt, "R9 repeat hit", out_chk, req_chk ^ 32'hFF);
        end
        check(armed == 1'b1, "R9 still armed", {31'd0, armed}, 32'd1);
        idle_req();
        reg_write(2'd3, 32'h0);
        drive_req(1'b1, 2'd0, 2'd0, 4'd0, 16'h0, 14'h0, 1'b0);
        check(out_chk == req_chk && !par_corrupt, "R2 after disarm clean", out_chk, req_chk);
        idle_req();

        // R11: parameter writes while armed are staged only
        reg_write(2'd0, 32'h6FBBC123);
        reg_write(2'd1, 32'h019);
        reg_write(2'd2, 32'h00000001);
        reg_write(2'd3, 32'h09);
        reg_write(2'd2, 32'h00000100);
        reg_write(2'd1, 32'h3E0);
        drive_req(1'b1, 2'd0, 2'd0, 4'd0, 16'h0, 14'h0, 1'b0);
        check(out_chk == req_chk, "R11 old match kept", out_chk, req_chk);
        @(negedge clk);
        drive_req(1'b1, 2'd1, 2'd2, 4'd5, 16'hBEEF, 14'h0123, 1'b0);
        check(out_chk == (req_chk ^ 32'h1), "R11 old mask kept", out_chk, req_chk ^ 32'h1);
        idle_req();
        reg_write(2'd3, 32'h09);
        drive_req(1'b1, 2'd0, 2'd0, 4'd0, 16'h0, 14'h0, 1'b0);
        check(out_chk == (req_chk ^ 32'h100), "R11 new params at rearm", out_chk, req_chk ^ 32'h100);
        idle_req();

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule